// File: doc/BRIEF.md
# Ternary Rule-Matrix Logic Controller

This block is a clocked logic controller whose behaviour lives entirely in a loadable table of rules rather than in a state table. Each rule holds a ternary condition over the input pins and the inner (feedback) variables. It also holds a ternary action over the inner variables and the output variables. On each active clock step, every rule whose condition holds fires in the same step. Every variable that a fired action names is set or cleared on the next edge. Variables named by no fired action keep their old value. Each controlled variable is therefore a set/reset flip-flop. Its set function is the OR of the matching rules that drive it to 1, and its reset function is the OR of those that drive it to 0.

The table is written one half-rule at a time through an address/data port while the controller is stopped. The controller then runs while `run_en` is high. If two fired rules disagree on a variable in the same step, that variable is left alone and a conflict flag is raised for that step. The inner variables start from a fixed parameter value at reset, so the automaton has a known initial state.

Top module: `rule_matrix_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `inner_q` takes `INIT_INNER`, `out_q` and `conflict` go to 0, and every rule is cleared. A cleared rule has no care bits in its condition, so it always matches, and no care bits in its action, so it changes nothing.
- R2: A ternary entry is a care bit (in `cfg_care`) and a value bit (in `cfg_val`), and care 0 means don't-care. `cfg_sel` 0 writes a condition and 1 writes an action. In a condition, bits [N_IN-1:0] are the inputs and bits [N_IN+N_INNER-1:N_IN] are the inner variables. In an action, bits [N_INNER-1:0] are the inner variables and bits [N_INNER+N_OUT-1:N_INNER] are the outputs.
- R3: A rule matches when each condition entry with care 1 equals the present value of its variable. Inputs are taken from `in_vec` and inner variables from `inner_q`.
- R4: With `run_en` high at an edge, all matching rules fire together. A variable that some fired rule drives to 1, and none drives to 0, becomes 1 after that edge, and the mirror case becomes 0.
- R5: With `run_en` high, a variable named by no fired action keeps its value across the edge.
- R6: If fired rules drive one variable to both 1 and 0 in one step, that variable keeps its value. `conflict` is then 1 for the cycle after that edge; otherwise it is 0 after a run step.
- R7: With `run_en` low at an edge, `inner_q` and `out_q` keep their values and `conflict` is 0 after it.
- R8: A write with `cfg_we` high is taken only when `run_en` is low. A write while running leaves the rule table unchanged.
- R9: A rule written at one edge governs the first run step after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | High: evaluate rules each edge; low: hold state, accept writes |
| in_vec | input | N_IN | Present input variables |
| cfg_we | input | 1 | Rule write strobe |
| cfg_sel | input | 1 | 0 = condition half, 1 = action half |
| cfg_rule | input | RW | Index of the rule written |
| cfg_care | input | DW | Care bits of the written half |
| cfg_val | input | DW | Value bits of the written half |
| inner_q | output | N_INNER | Inner (feedback) variables |
| out_q | output | N_OUT | Output variables |
| conflict | output | 1 | Contradictory drive seen in the last run step |

## Verification
The two functions that meet in one cycle are setting and clearing the same variable: two matching rules can name one variable with opposite values on the same edge. The bench loads a directed pair of rules whose conditions are all don't-care and whose actions disagree on one inner bit. It then loads random sparse tables where such collisions occur by chance. Each case is judged by a bench model: the contested bit must hold, uncontested bits in the same step must still move, and the flag must rise for exactly that step. A rule write attempted during a conflicting run step must leave the conflict in place on the next step.

// File: rtl/rule_matrix_pkg.sv
// Shared helpers for the ternary rule-matrix controller.
// Assumes: all sizes are elaboration-time constants.
package rule_matrix_pkg;

    // Which half of a rule a configuration write targets.
    typedef enum logic {
        TBL_COND   = 1'b0,
        TBL_ACTION = 1'b1
    } tbl_sel_e;

    // Larger of two widths.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Index width for n entries, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rule_matrix_store.sv
// Rule table: per rule, a condition (care/value over inputs+inner) and an
// action (care/value over inner+outputs). Cleared on reset so every rule
// matches and acts on nothing.
// Assumes: wr_en is already qualified by the caller (controller stopped).
module rule_matrix_store
    import rule_matrix_pkg::*;
#(
    parameter int unsigned N_RULES = 8,
    parameter int unsigned NC      = 8,
    parameter int unsigned NE      = 8,
    parameter int unsigned DW      = 8,
    parameter int unsigned RW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [RW-1:0] wr_rule,
    input  logic [DW-1:0] wr_care,
    input  logic [DW-1:0] wr_val,
    output logic [NC-1:0] c_care [N_RULES],
    output logic [NC-1:0] c_val  [N_RULES],
    output logic [NE-1:0] e_care [N_RULES],
    output logic [NE-1:0] e_val  [N_RULES]
);

    tbl_sel_e sel;
    assign sel = tbl_sel_e'(wr_sel);

    for (genvar r = 0; r < N_RULES; r++) begin : g_rule
        logic hit_addr;
        assign hit_addr = wr_en && (wr_rule == RW'(r));

        // Holds one rule; the write replaces one half of it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_care[r] <= '0;
                c_val[r]  <= '0;
                e_care[r] <= '0;
                e_val[r]  <= '0;
            end else if (hit_addr) begin
                if (sel == TBL_COND) begin
                    c_care[r] <= wr_care[NC-1:0];
                    c_val[r]  <= wr_val[NC-1:0];
                end else begin
                    e_care[r] <= wr_care[NE-1:0];
                    e_val[r]  <= wr_val[NE-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/rule_matrix_fire.sv
// Product and sum planes: matches every condition against the present
// variables, then ORs the actions of matching rules into per-variable
// set and reset requests.
// Assumes: purely combinational; no priority among rules.
module rule_matrix_fire #(
    parameter int unsigned N_RULES = 8,
    parameter int unsigned NC      = 8,
    parameter int unsigned NE      = 8
) (
    input  logic [NC-1:0] present,
    input  logic [NC-1:0] c_care [N_RULES],
    input  logic [NC-1:0] c_val  [N_RULES],
    input  logic [NE-1:0] e_care [N_RULES],
    input  logic [NE-1:0] e_val  [N_RULES],
    output logic [NE-1:0] set_v,
    output logic [NE-1:0] clr_v
);

    logic [N_RULES-1:0] hit;

    for (genvar r = 0; r < N_RULES; r++) begin : g_match
        // A rule matches when no cared entry disagrees with the present value.
        assign hit[r] = ((present ^ c_val[r]) & c_care[r]) == '0;
    end

    // Collects set and reset demands from all matching rules.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int r = 0; r < N_RULES; r++) begin
            set_v = set_v | ({NE{hit[r]}} & e_care[r] &  e_val[r]);
            clr_v = clr_v | ({NE{hit[r]}} & e_care[r] & ~e_val[r]);
        end
    end

endmodule

// File: rtl/rule_matrix_srbank.sv
// Bank of set/reset flip-flops, one per controlled variable. A lone set
// or lone reset acts on a run step; both together hold the bit and are
// reported on the conflict flag.
// Assumes: INIT gives the reset value of every bit.
module rule_matrix_srbank #(
    parameter int unsigned     NE   = 8,
    parameter logic [NE-1:0]   INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [NE-1:0] set_v,
    input  logic [NE-1:0] clr_v,
    output logic [NE-1:0] q,
    output logic          conflict
);

    for (genvar i = 0; i < NE; i++) begin : g_bit
        logic bit_q;

        // One set/reset cell with hold on contradiction or idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= INIT[i];
            end else if (step) begin
                case ({set_v[i], clr_v[i]})
                    2'b10:   bit_q <= 1'b1;
                    2'b01:   bit_q <= 1'b0;
                    default: bit_q <= bit_q;
                endcase
            end
        end

        assign q[i] = bit_q;
    end

    // Flags a step in which any variable was driven both ways.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conflict <= 1'b0;
        end else begin
            conflict <= step && ((set_v & clr_v) != '0);
        end
    end

endmodule

// File: rtl/rule_matrix_ctrl.sv
// Top of the ternary rule-matrix controller. Rules are written while
// stopped; while running, all matching rules fire in parallel on each
// edge and unnamed variables hold (inertial behaviour).
// Assumes: run_en and cfg_* are synchronous to clk.
module rule_matrix_ctrl
    import rule_matrix_pkg::*;
#(
    parameter int unsigned          N_IN       = 4,
    parameter int unsigned          N_INNER    = 4,
    parameter int unsigned          N_OUT      = 4,
    parameter int unsigned          N_RULES    = 8,
    parameter logic [N_INNER-1:0]   INIT_INNER = 4'b0110,
    localparam int unsigned         NC         = N_IN + N_INNER,
    localparam int unsigned         NE         = N_INNER + N_OUT,
    localparam int unsigned         DW         = max2(NC, NE),
    localparam int unsigned         RW         = idx_width(N_RULES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [N_IN-1:0]    in_vec,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [RW-1:0]      cfg_rule,
    input  logic [DW-1:0]      cfg_care,
    input  logic [DW-1:0]      cfg_val,
    output logic [N_INNER-1:0] inner_q,
    output logic [N_OUT-1:0]   out_q,
    output logic               conflict
);

    localparam logic [NE-1:0] INIT_STATE = {{N_OUT{1'b0}}, INIT_INNER};

    logic [NC-1:0] c_care [N_RULES];
    logic [NC-1:0] c_val  [N_RULES];
    logic [NE-1:0] e_care [N_RULES];
    logic [NE-1:0] e_val  [N_RULES];
    logic [NE-1:0] set_v;
    logic [NE-1:0] clr_v;
    logic [NE-1:0] bank_q;
    logic [NC-1:0] present;
    logic          wr_ok;

    // Writes are only accepted while the controller is stopped.
    assign wr_ok   = cfg_we && !run_en;
    assign present = {inner_q, in_vec};

    rule_matrix_store #(
        .N_RULES (N_RULES),
        .NC      (NC),
        .NE      (NE),
        .DW      (DW),
        .RW      (RW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_sel  (cfg_sel),
        .wr_rule (cfg_rule),
        .wr_care (cfg_care),
        .wr_val  (cfg_val),
        .c_care  (c_care),
        .c_val   (c_val),
        .e_care  (e_care),
        .e_val   (e_val)
    );

    rule_matrix_fire #(
        .N_RULES (N_RULES),
        .NC      (NC),
        .NE      (NE)
    ) u_fire (
        .present (present),
        .c_care  (c_care),
        .c_val   (c_val),
        .e_care  (e_care),
        .e_val   (e_val),
        .set_v   (set_v),
        .clr_v   (clr_v)
    );

    rule_matrix_srbank #(
        .NE   (NE),
        .INIT (INIT_STATE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (run_en),
        .set_v    (set_v),
        .clr_v    (clr_v),
        .q        (bank_q),
        .conflict (conflict)
    );

    assign inner_q = bank_q[N_INNER-1:0];
    assign out_q   = bank_q[NE-1:N_INNER];

endmodule

// File: rtl/rule_matrix_ctrl_chk.sv
// Checker for rule_matrix_ctrl: relates the set/reset requests of one
// cycle to the register state and flag of the next.
// Assumes: bound to every instance of the top module.
module rule_matrix_ctrl_chk #(
    parameter int unsigned   NE   = 8,
    parameter logic [NE-1:0] INIT = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic [NE-1:0] set_v,
    input logic [NE-1:0] clr_v,
    input logic [NE-1:0] state,
    input logic          conflict
);

    logic rst_seen;

    // Remembers that a reset edge has occurred.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: reset values hold once a reset edge has passed.
    always @(negedge clk) begin
        if (rst_seen && !rst_n) begin
            a_reset_vals_r1: assert (state == INIT && !conflict)
                else $error("reset values wrong");
        end
    end

    p_lone_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (((state & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)) &&
                    ((state & $past(clr_v & ~set_v)) == '0)))
        else $error("lone set/reset not applied");

    p_hold_unnamed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (((state ^ $past(state)) & ~$past(set_v ^ clr_v)) == '0))
        else $error("unnamed or contested variable changed");

    p_conflict_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (conflict == ($past(set_v & clr_v) != '0)))
        else $error("conflict flag mismatch");

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(state) && !conflict))
        else $error("state moved while stopped");

endmodule

bind rule_matrix_ctrl rule_matrix_ctrl_chk #(
    .NE   (NE),
    .INIT (INIT_STATE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .set_v    (set_v),
    .clr_v    (clr_v),
    .state    (bank_q),
    .conflict (conflict)
);

// File: tb/rule_matrix_ctrl_bench.sv
module rule_matrix_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN = 4, N_INNER = 4, N_OUT = 4, N_RULES = 8;
    localparam logic [N_INNER-1:0] INIT_INNER = 4'b0110;
    localparam int NC = N_IN + N_INNER, NE = N_INNER + N_OUT;
    localparam int DW = (NC > NE) ? NC : NE;
    localparam int RW = 3;

    logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [N_IN-1:0] in_vec = '0;
    logic [RW-1:0] cfg_rule = '0;
    logic [DW-1:0] cfg_care = '0, cfg_val = '0;
    logic [N_INNER-1:0] inner_q;
    logic [N_OUT-1:0] out_q;
    logic conflict;

    int n_checks = 0, n_err = 0;
    bit finished = 0;

    // Bench model of the rule table and state
    logic [NC-1:0] m_cc [N_RULES];
    logic [NC-1:0] m_cv [N_RULES];
    logic [NE-1:0] m_ec [N_RULES];
    logic [NE-1:0] m_ev [N_RULES];
    logic [NE-1:0] exp_state;
    logic exp_conf;

    always #(CLK_PERIOD/2) clk = ~clk;

    rule_matrix_ctrl #(
        .N_IN(N_IN), .N_INNER(N_INNER), .N_OUT(N_OUT), .N_RULES(N_RULES),
        .INIT_INNER(INIT_INNER)
    ) u_rule_matrix_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .in_vec(in_vec),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_rule(cfg_rule),
        .cfg_care(cfg_care), .cfg_val(cfg_val),
        .inner_q(inner_q), .out_q(out_q), .conflict(conflict)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " inner_q"}, 32'(inner_q), 32'(exp_state[N_INNER-1:0]));
        chk({tag, " out_q"}, 32'(out_q), 32'(exp_state[NE-1:N_INNER]));
        chk({tag, " conflict"}, 32'(conflict), 32'(exp_conf));
    endtask

    // Next state and flag from the requirements (R3..R6), bit by bit.
    task automatic model_step(input logic [N_IN-1:0] inv);
        logic [NC-1:0] pres;
        logic [NE-1:0] nxt;
        logic c;
        pres = {exp_state[N_INNER-1:0], inv};
        nxt = exp_state;
        c = 1'b0;
        for (int v = 0; v < NE; v++) begin
            bit want1, want0;
            want1 = 0; want0 = 0;
            for (int r = 0; r < N_RULES; r++) begin
                bit ok;
                ok = 1;
                for (int b = 0; b < NC; b++)
                    if (m_cc[r][b] && (m_cv[r][b] != pres[b])) ok = 0;
                if (ok && m_ec[r][v]) begin
                    if (m_ev[r][v]) want1 = 1; else want0 = 1;
                end
            end
            if (want1 && want0) c = 1'b1;
            else if (want1) nxt[v] = 1'b1;
            else if (want0) nxt[v] = 1'b0;
        end
        exp_state = nxt;
        exp_conf = c;
    endtask

    task automatic step(input logic run, input logic [N_IN-1:0] inv);
        run_en = run; in_vec = inv; cfg_we = 1'b0;
        if (run) model_step(inv); else exp_conf = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic run, input int r, input logic sel,
                      input logic [DW-1:0] care, input logic [DW-1:0] val);
        run_en = run; cfg_we = 1'b1; cfg_sel = sel; cfg_rule = RW'(r);
        cfg_care = care; cfg_val = val;
        if (run) model_step(in_vec);
        else begin
            exp_conf = 1'b0;
            if (!sel) begin m_cc[r] = care[NC-1:0]; m_cv[r] = val[NC-1:0]; end
            else      begin m_ec[r] = care[NE-1:0]; m_ev[r] = val[NE-1:0]; end
        end
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < N_RULES; r++) begin
            m_cc[r] = '0; m_cv[r] = '0; m_ec[r] = '0; m_ev[r] = '0;
        end
        exp_state = {{N_OUT{1'b0}}, INIT_INNER};
        exp_conf = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;

        // R1: cleared rules always match but change nothing
        step(1'b1, 4'hA);
        check_all("R1 cleared table inert");

        // R7: stopped controller ignores inputs
        step(1'b0, 4'h5);
        check_all("R7 idle hold");

        // R2/R3: rule0 cares only about input bit0=1 -> out bit0 := 1
        wr(1'b0, 0, 1'b0, DW'(1), DW'(1));
        wr(1'b0, 0, 1'b1, DW'(1) << N_INNER, DW'(1) << N_INNER);
        // rule1: input bit0=0 -> out bit0 := 0, inner bit3 := 1
        wr(1'b0, 1, 1'b0, DW'(1), DW'(0));
        wr(1'b0, 1, 1'b1, (DW'(1) << N_INNER) | DW'(8), DW'(8));
        step(1'b1, 4'b1111);
        check_all("R3 match dont-care R2 R9");
        chk("R4 out bit0 set", 32'(out_q[0]), 32'd1);
        chk("R5 inner untouched", 32'(inner_q), 32'(INIT_INNER));
        step(1'b1, 4'b0000);
        check_all("R4 parallel fire");
        chk("R4 out bit0 cleared", 32'(out_q[0]), 32'd0);
        chk("R4 inner bit3 set", 32'(inner_q[3]), 32'd1);

        // R6: rules 2 and 3 always match and disagree on inner bit0
        wr(1'b0, 2, 1'b1, DW'(1), DW'(1));
        wr(1'b0, 3, 1'b1, DW'(1) | (DW'(2) << N_INNER), DW'(0) | (DW'(2) << N_INNER));
        step(1'b1, 4'b0000);
        check_all("R6 conflict step");
        chk("R6 conflict flag", 32'(conflict), 32'd1);
        chk("R6 contested inner bit0 held", 32'(inner_q[0]), 32'd0);
        chk("R6 uncontested out bit1 moved", 32'(out_q[1]), 32'd1);

        // R8: delete attempt while running is ignored; conflict persists
        wr(1'b1, 3, 1'b1, DW'(0), DW'(0));
        check_all("R8 write during run");
        step(1'b1, 4'b0000);
        check_all("R8 table unchanged");
        chk("R8 conflict still present", 32'(conflict), 32'd1);

        // R9: idle delete takes effect on the next run step
        wr(1'b0, 3, 1'b1, DW'(0), DW'(0));
        chk("R7 flag low while stopped", 32'(conflict), 32'd0);
        step(1'b1, 4'b0000);
        check_all("R9 new rule governs");
        chk("R9 inner bit0 now set", 32'(inner_q[0]), 32'd1);

        // Random phase: sparse random tables, mostly running
        for (int round = 0; round < 30; round++) begin
            for (int r = 0; r < N_RULES; r++) begin
                logic [DW-1:0] cc, ec;
                cc = DW'($urandom & $urandom & $urandom);
                ec = DW'($urandom & $urandom);
                wr(1'b0, r, 1'b0, cc, DW'($urandom));
                wr(1'b0, r, 1'b1, ec, DW'($urandom));
            end
            for (int s = 0; s < 60; s++) begin
                if (($urandom % 16) == 0)
                    wr(1'b1, int'($urandom % N_RULES), 1'($urandom), DW'($urandom), DW'($urandom));
                else
                    step(($urandom % 10) != 0, N_IN'($urandom));
                check_all("R4 R5 R6 R8 random");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule